// File: doc/BRIEF.md
# Bit-Serial CRC-32 Generator and Checker

This block computes the common 32-bit cyclic redundancy checksum one message bit per clock. Bytes arrive on a parallel byte port and are shifted into the checksum register least significant bit first. The register is a feedback shift register for the generator 0x04C11DB7, whose x^32 term is implicit. Message bits enter at the high-order end of the register. This premultiplies the message by x^32, so the register always holds the finished remainder of the bits seen so far and no 32 zero bits have to be fed in at the end of a frame.

In generate mode the block presents the transmit checksum on a 32-bit output. That value is the bitwise complement of the register, bit-reversed so that it can be sent least significant byte first, each byte least significant bit first. In check mode the receiver feeds the message followed by the received checksum in that same order. When the last bit of a byte leaves the register equal to the fixed residue 0xC704DD7B, a good-frame flag is raised. A clear input starts a new frame.

Top module: `crc32_serial_engine`

## Requirements
- R1: While reset is asserted, busy is 0, crc_ok is 0 and crc_out is 0x00000000, because the register is preset to all ones.
- R2: A byte is taken when byte_valid is 1, busy is 0 and clear is 0 at a rising clock edge. busy is then 1 for exactly the next 7 cycles, so a new byte can be taken every 8 cycles.
- R3: byte_valid while busy is 1 has no effect: the byte in progress finishes and the checksum reflects only the accepted byte.
- R4: Each accepted byte is processed from bit 0 to bit 7. For each bit b with register msb m, the register shifts left one place and is XORed with 0x04C11DB7 when b XOR m is 1.
- R5: crc_out equals the bit-reversed complement of the register. For any byte string this is the standard CRC-32 (reflected constant 0xEDB88320, preset all ones, final complement), for example 0xCBF43926 for the ASCII string "123456789".
- R6: In check mode (mode_check = 1), after a message is followed by its checksum, sent as crc_out bits 7:0, 15:8, 23:16, 31:24 in that order, crc_ok is 1 once busy is 0.
- R7: In check mode, a frame whose checksum has any single bit flipped leaves crc_ok at 0.
- R8: In generate mode (mode_check = 0), crc_ok never rises, even for a frame that would pass in check mode.
- R9: clear returns the register to all ones (crc_out = 0), ends any byte in progress (busy = 0) and drops crc_ok on the next cycle. A byte offered in the same cycle as clear is not taken.
- R10: crc_ok is updated only at the edge that processes the last bit of a byte. It is 0 while busy is 1 and returns to 0 when the next byte starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Start a new frame: preset the register and abort serialisation |
| mode_check | input | 1 | 1 = check received frames, 0 = generate checksum |
| byte_valid | input | 1 | A byte is offered on byte_data |
| byte_data | input | 8 | Byte to fold into the checksum, sent LSB first |
| busy | output | 1 | Serialiser is still shifting the current byte |
| crc_out | output | 32 | Complemented, bit-reversed checksum of the bytes so far |
| crc_ok | output | 1 | Check-mode flag: register equals the good-frame residue |

## Verification
The assertions assume that mode_check does not change while a byte is being serialised. They also assume that byte_valid and byte_data carry known values at every sampled edge. The stimulus drives every input on the falling edge and changes the mode only between frames, after clear. A new byte is offered only after busy has been seen low, except in the cases that deliberately offer a byte while busy is high or while clear is asserted.

// File: rtl/crc32_serial_pkg.sv
package crc32_serial_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY    = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_PRESET  = {CRC_W{1'b1}};
  localparam logic [CRC_W-1:0] CRC_RESIDUE = 32'hC704_DD7B;

  // One division step, left-shift form, message bit entering at the msb end.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                input logic [CRC_W-1:0] poly,
                                                input logic din);
    logic fb;
    fb = din ^ cur[CRC_W-1];
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

  // Complement and bit-reverse the register into transmit order.
  function automatic logic [CRC_W-1:0] crc_present(input logic [CRC_W-1:0] cur);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = ~cur[CRC_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/crc_byte_serializer.sv
module crc_byte_serializer #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              busy,
  output logic              bit_en,
  output logic              bit_in,
  output logic              last_bit
);
  localparam int unsigned CNT_W = $clog2(BYTE_W) + 1;
  localparam logic [CNT_W-1:0] REMAIN = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] hold_q;
  logic [CNT_W-1:0]  left_q;
  logic              busy_q;
  logic              accept;

  assign accept   = byte_valid & ~busy_q & ~clear;
  assign bit_en   = accept | busy_q;
  assign bit_in   = busy_q ? hold_q[0] : byte_data[0];
  assign last_bit = busy_q & (left_q == CNT_W'(1));
  assign busy     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (clear) begin
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (accept) begin
      hold_q <= byte_data >> 1;
      left_q <= REMAIN;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      hold_q <= hold_q >> 1;
      left_q <= left_q - CNT_W'(1);
      if (left_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/crc_lfsr.sv
module crc_lfsr
  import crc32_serial_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY   = CRC_POLY,
  parameter logic [CRC_W-1:0] PRESET = CRC_PRESET
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bit_en,
  input  logic             bit_in,
  output logic [CRC_W-1:0] state,
  output logic [CRC_W-1:0] state_nx
);
  logic [CRC_W-1:0] state_q;

  always_comb begin
    if (clear)       state_nx = PRESET;
    else if (bit_en) state_nx = crc_step(state_q, POLY, bit_in);
    else             state_nx = state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PRESET;
    else        state_q <= state_nx;
  end

  assign state = state_q;
endmodule

// File: rtl/crc_residue_flag.sv
module crc_residue_flag
  import crc32_serial_pkg::*;
#(
  parameter logic [CRC_W-1:0] RESIDUE = CRC_RESIDUE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             mode_check,
  input  logic             bit_en,
  input  logic             last_bit,
  input  logic [CRC_W-1:0] state_nx,
  output logic             ok
);
  logic ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ok_q <= 1'b0;
    else if (clear)    ok_q <= 1'b0;
    else if (last_bit) ok_q <= mode_check & (state_nx == RESIDUE);
    else if (bit_en)   ok_q <= 1'b0;
  end

  assign ok = ok_q;
endmodule

// File: rtl/crc32_serial_engine.sv
module crc32_serial_engine
  import crc32_serial_pkg::*;
#(
  parameter int unsigned      BYTE_W  = 8,
  parameter logic [CRC_W-1:0] POLY    = CRC_POLY,
  parameter logic [CRC_W-1:0] PRESET  = CRC_PRESET,
  parameter logic [CRC_W-1:0] RESIDUE = CRC_RESIDUE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              mode_check,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              busy,
  output logic [CRC_W-1:0]  crc_out,
  output logic              crc_ok
);
  // Named internal events, visible to the bound checker.
  logic             bit_en;
  logic             bit_in;
  logic             last_bit;
  logic [CRC_W-1:0] crc_state;
  logic [CRC_W-1:0] crc_state_nx;

  crc_byte_serializer #(.BYTE_W(BYTE_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .busy(busy), .bit_en(bit_en), .bit_in(bit_in), .last_bit(last_bit)
  );

  crc_lfsr #(.POLY(POLY), .PRESET(PRESET)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .bit_en(bit_en), .bit_in(bit_in),
    .state(crc_state), .state_nx(crc_state_nx)
  );

  crc_residue_flag #(.RESIDUE(RESIDUE)) u_flag (
    .clk(clk), .rst_n(rst_n), .clear(clear), .mode_check(mode_check),
    .bit_en(bit_en), .last_bit(last_bit), .state_nx(crc_state_nx),
    .ok(crc_ok)
  );

  // Transmit order: complemented register, bit-reversed.
  for (genvar i = 0; i < CRC_W; i++) begin : g_out
    assign crc_out[i] = ~crc_state[CRC_W-1-i];
  end
endmodule

// File: rtl/crc32_serial_engine_chk.sv
module crc32_serial_engine_chk #(
  parameter int unsigned      BYTE_W  = 8,
  parameter int unsigned      W       = 32,
  parameter logic [W-1:0]     RESIDUE = 32'hC704_DD7B
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clear,
  input logic         mode_check,
  input logic         busy,
  input logic         crc_ok,
  input logic [W-1:0] crc_out,
  input logic         bit_en,
  input logic         bit_in,
  input logic [W-1:0] state
);
  localparam int unsigned SPAN = BYTE_W - 1;
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_run < SPAN); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !clear) |=> $stable(state)); // R3

  AST_FEEDBACK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !clear) |=> state[0] == $past(bit_in ^ state[W-1])); // R4

  AST_OK_AT_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_ok) |-> state == RESIDUE); // R6

  AST_OK_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_ok) |-> $past(mode_check)); // R8

  AST_CLEAR_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_out == '0 && !busy && !crc_ok)); // R9

  AST_OK_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> !busy); // R10

  AST_OK_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_ok) |-> $fell(busy)); // R10
endmodule

bind crc32_serial_engine crc32_serial_engine_chk #(
  .BYTE_W(BYTE_W), .W(crc32_serial_pkg::CRC_W), .RESIDUE(RESIDUE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .mode_check(mode_check),
  .busy(busy), .crc_ok(crc_ok), .crc_out(crc_out),
  .bit_en(bit_en), .bit_in(bit_in), .state(crc_state)
);

// File: tb/crc32_serial_engine_test.sv
module crc32_serial_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        mode_check = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        busy;
  logic        crc_ok;
  logic [31:0] crc_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc32_serial_engine uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .mode_check(mode_check),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .busy(busy), .crc_out(crc_out), .crc_ok(crc_ok)
  );

  // Reference in the right-shifting reflected form, kept as the running remainder.
  function automatic logic [31:0] ref_upd(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    while (busy) @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic do_clear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int k = 0; k < 4; k++) send_byte(w[8*k +: 8]);
  endtask

  initial begin : watchdog
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] m;
    logic [31:0] c;
    int n;
    string s;

    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", {31'h0, busy}, 32'h0);
    check(crc_ok == 1'b0, "R1 crc_ok in reset", {31'h0, crc_ok}, 32'h0);
    check(crc_out == 32'h0, "R1 crc_out in reset", crc_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: busy span after an accepted byte
    send_byte(8'hA5);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    check(n == 7, "R2 busy cycles", n, 7);
    check(crc_out == ~ref_upd(32'hFFFF_FFFF, 8'hA5), "R2 byte result",
          crc_out, ~ref_upd(32'hFFFF_FFFF, 8'hA5));

    // R3: offers while busy are ignored
    do_clear();
    send_byte(8'h3C);
    byte_valid = 1'b1;
    byte_data  = 8'hFF;
    repeat (3) @(negedge clk);
    byte_valid = 1'b0;
    wait_idle();
    check(crc_out == ~ref_upd(32'hFFFF_FFFF, 8'h3C), "R3 ignore while busy",
          crc_out, ~ref_upd(32'hFFFF_FFFF, 8'h3C));

    // R4 / R8: every single-byte message in generate mode
    for (int b = 0; b < 256; b++) begin
      do_clear();
      send_byte(8'(b));
      wait_idle();
      m = ~ref_upd(32'hFFFF_FFFF, 8'(b));
      check(crc_out == m, "R4 single byte sweep", crc_out, m);
      check(crc_ok == 1'b0, "R8 no flag in generate", {31'h0, crc_ok}, 32'h0);
    end

    // R5: known string vector
    do_clear();
    s = "123456789";
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
    wait_idle();
    check(crc_out == 32'hCBF4_3926, "R5 string vector", crc_out, 32'hCBF4_3926);

    // R5: multi-byte pattern against the running model
    do_clear();
    m = 32'hFFFF_FFFF;
    for (int i = 0; i < 40; i++) begin
      send_byte(8'((i * 37) ^ 8'h5A));
      m = ref_upd(m, 8'((i * 37) ^ 8'h5A));
    end
    wait_idle();
    check(crc_out == ~m, "R5 multi-byte pattern", crc_out, ~m);

    // R9: clear in the middle of a byte, with a byte offered at the same time
    do_clear();
    send_byte(8'h77);
    clear = 1'b1;
    byte_valid = 1'b1;
    byte_data = 8'h12;
    @(negedge clk);
    clear = 1'b0;
    byte_valid = 1'b0;
    check(busy == 1'b0, "R9 busy after clear", {31'h0, busy}, 32'h0);
    check(crc_out == 32'h0, "R9 preset after clear", crc_out, 32'h0);
    send_byte(8'h5A);
    wait_idle();
    check(crc_out == ~ref_upd(32'hFFFF_FFFF, 8'h5A), "R9 fresh frame",
          crc_out, ~ref_upd(32'hFFFF_FFFF, 8'h5A));

    // R6 / R10: good frames in check mode
    mode_check = 1'b1;
    for (int b = 0; b < 256; b++) begin
      do_clear();
      send_byte(8'(b));
      wait_idle();
      c = crc_out;
      send_word(c);
      check(crc_ok == 1'b0, "R10 flag low while busy", {31'h0, crc_ok}, 32'h0);
      wait_idle();
      check(crc_ok == 1'b1, "R6 good frame flagged", {31'h0, crc_ok}, 32'h1);
    end

    // R10: flag drops when the next byte starts
    send_byte(8'h00);
    check(crc_ok == 1'b0, "R10 flag drops on new byte", {31'h0, crc_ok}, 32'h0);
    wait_idle();

    // R9: clear drops the flag
    do_clear();
    send_byte(8'h99);
    wait_idle();
    send_word(crc_out);
    wait_idle();
    check(crc_ok == 1'b1, "R6 frame before clear", {31'h0, crc_ok}, 32'h1);
    do_clear();
    check(crc_ok == 1'b0, "R9 flag cleared", {31'h0, crc_ok}, 32'h0);

    // R7: single-bit checksum errors
    for (int b = 0; b < 256; b++) begin
      do_clear();
      send_byte(8'(b));
      wait_idle();
      c = crc_out ^ (32'h1 << (b % 32));
      send_word(c);
      wait_idle();
      check(crc_ok == 1'b0, "R7 corrupted frame", {31'h0, crc_ok}, 32'h0);
    end

    // R8: a valid frame in generate mode raises nothing
    mode_check = 1'b0;
    do_clear();
    send_byte(8'h42);
    wait_idle();
    send_word(crc_out);
    wait_idle();
    check(crc_ok == 1'b0, "R8 generate mode frame", {31'h0, crc_ok}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule